// File: doc/BRIEF.md
# Sample-Rate Clock Output Divider

This block produces a reference clock for external parts from the internal synthesizer clock. The division ratio follows the class of the audio sample rate being decoded. The high rates pass the clock through unchanged. The middle rates halve it. The low rates quarter it. A configuration word can add one more halving on top of that ratio, or it can bypass the scaler so that the raw clock always reaches the output.

The output runs only while the DSP or the audio codec is enabled. The configuration word is writable only while the DSP is enabled. Whatever was last written stays in force after the DSP is switched off. When the division ratio changes, the new ratio takes effect at a counter wrap, so the output never shows a runt pulse. The divided clock comes from a register toggle and has a 50% duty cycle.

Top module: `clkout_scaler`

## Requirements
- R1: `clk_out` is held low while both `dsp_en` and `codec_en` are low, and it runs whenever either of them is high.
- R2: Rate codes give these ratios: 0 (48 kHz), 1 (44.1 kHz) and 2 (32 kHz) divide by 1; 3 (24 kHz), 4 (22.05 kHz) and 5 (16 kHz) divide by 2; 6 (12 kHz), 7 (11.025 kHz) and 8 (8 kHz) divide by 4.
- R3: Rate codes 9 to 15 divide by 1.
- R4: When configuration bit 8 is set, the output is the undivided clock for every rate code.
- R5: When bit 8 is clear and bit 17 is set, the ratio from R2 or R3 is doubled.
- R6: A write (`cfg_we`) loads `cfg_wdata` only when `dsp_en` is high. A write made while `dsp_en` is low changes nothing at the output.
- R7: A configuration that has been loaded stays in effect after `dsp_en` falls, as long as `codec_en` keeps the output running.
- R8: After reset the configuration is all zeros, so the scaler is on and the extra halving is off. The output is low until an enable is seen.
- R9: A new ratio is applied only at the end of a complete output period, so every high pulse lasts a full half period of either the old ratio or the new ratio.
- R10: For every ratio the output is high for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_synth | input | 1 | Synthesizer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 4 | Code of the decoded sample rate |
| dsp_en | input | 1 | DSP enable control bit |
| codec_en | input | 1 | Audio codec enable control bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 18 | Configuration word to write |
| clk_out | output | 1 | Gated, divided clock output |

## Verification
The hardest case to reach is a ratio change that arrives in the middle of an output period. To produce it, the bench lets the divide-by-4 output settle and then switches the rate code to a divide-by-2 rate partway through a period. It then checks that every complete high pulse it sees lasts a full half period of either the old ratio or the new one. A separate sequence writes the configuration while only the codec is enabled, then writes it again with the DSP enabled, then turns the DSP off. The output frequency is measured after each step.

// File: rtl/clkout_scaler.sv
module clkout_scaler #(
  parameter int CFG_W      = 18,
  parameter int BYPASS_BIT = 8,
  parameter int EXTRA_BIT  = 17
) (
  input  logic             clk_synth,
  input  logic             rst_n,
  input  logic [3:0]       rate_code,
  input  logic             dsp_en,
  input  logic             codec_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             clk_out
);

  logic [CFG_W-1:0] cfg_q;
  logic             en_q;
  logic [1:0]       sh_q;
  logic [1:0]       base_sh;
  logic [1:0]       tgt_sh;
  logic [2:0]       cnt_q;
  logic [3:0]       ratio_q;
  logic [2:0]       half_m1;
  logic             div_q;
  logic             gate_n;

  always_ff @(posedge clk_synth or negedge rst_n)
    if (!rst_n)                cfg_q <= '0;
    else if (cfg_we && dsp_en) cfg_q <= cfg_wdata;

  always_comb begin
    unique case (rate_code)
      4'd3, 4'd4, 4'd5: base_sh = 2'd1;
      4'd6, 4'd7, 4'd8: base_sh = 2'd2;
      default:          base_sh = 2'd0;
    endcase
    if (cfg_q[BYPASS_BIT])     tgt_sh = 2'd0;
    else if (cfg_q[EXTRA_BIT]) tgt_sh = base_sh + 2'd1;
    else                       tgt_sh = base_sh;
  end

  assign ratio_q = 4'd1 << sh_q;
  assign half_m1 = ratio_q[3:1] - 3'd1;

  always_ff @(posedge clk_synth or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      sh_q  <= 2'd0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      en_q <= dsp_en | codec_en;
      if (!en_q) begin
        cnt_q <= '0;
        div_q <= 1'b0;
        sh_q  <= tgt_sh;
      end else if (sh_q == 2'd0 || cnt_q == half_m1) begin
        cnt_q <= '0;
        if (sh_q == 2'd0 || div_q) begin
          div_q <= 1'b0;
          sh_q  <= tgt_sh;
        end else begin
          div_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 3'd1;
      end
    end

  always_ff @(negedge clk_synth or negedge rst_n)
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= en_q && (sh_q == 2'd0);

  assign clk_out = (clk_synth & gate_n) | div_q;

  AST_OFF_RESETS_DIVIDER: assert property (@(posedge clk_synth) disable iff (!rst_n)
    !en_q |=> (!div_q && cnt_q == 3'd0)) else $error("off state not cleared"); // R1
  AST_CFG_LOCKED: assert property (@(posedge clk_synth) disable iff (!rst_n)
    !dsp_en |=> $stable(cfg_q)) else $error("cfg changed without dsp"); // R6
  AST_CFG_LOADED: assert property (@(posedge clk_synth) disable iff (!rst_n)
    (cfg_we && dsp_en) |=> cfg_q == $past(cfg_wdata)) else $error("cfg write lost"); // R6
  AST_RATIO_AT_WRAP: assert property (@(posedge clk_synth) disable iff (!rst_n)
    (en_q && $past(en_q) && sh_q != $past(sh_q)) |-> ($past(sh_q) == 2'd0 || $past(div_q)))
    else $error("ratio changed mid period"); // R9
  AST_HALF_BOUND: assert property (@(posedge clk_synth) disable iff (!rst_n)
    (en_q && sh_q != 2'd0) |-> cnt_q <= half_m1) else $error("counter overran half period"); // R10
  AST_UNITY_NO_TOGGLE: assert property (@(posedge clk_synth) disable iff (!rst_n)
    (sh_q == 2'd0) |-> !div_q) else $error("toggle active in pass-through"); // R4

endmodule

// File: tb/clkout_scaler_bench.sv
module clkout_scaler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rate_code = 4'd0;
  logic        dsp_en = 1'b0;
  logic        codec_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [17:0] cfg_wdata = '0;
  logic        clk_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  typedef struct { int exp_rises; int exp_highs; string tag; } item_t;
  item_t q[$];
  logic  done = 1'b0;

  always #4 clk = ~clk;

  clkout_scaler u_clkout_scaler (
    .clk_synth(clk), .rst_n(rst_n), .rate_code(rate_code), .dsp_en(dsp_en),
    .codec_en(codec_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clk_out(clk_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ratio(int ratio, string tag);
    item_t it;
    it.exp_rises = (ratio == 0) ? 0 : 64 / ratio;
    it.exp_highs = (ratio == 0) ? 0 : 64;
    it.tag = tag;
    settle(24);
    done = 1'b0;
    q.push_back(it);
    wait (done);
  endtask

  task automatic write_cfg(logic [17:0] v);
    @(negedge clk);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      logic prev, s;
      int rises, highs;
      wait (q.size() > 0);
      it = q.pop_front();
      @(posedge clk); #2 prev = clk_out;
      rises = 0; highs = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk); #2 s = clk_out;
        if (s && !prev) rises++;
        if (s) highs++;
        prev = s;
        @(posedge clk); #2 s = clk_out;
        if (s && !prev) rises++;
        if (s) highs++;
        prev = s;
      end
      n_tests++;
      if (rises != it.exp_rises || highs != it.exp_highs) begin
        n_fail++;
        $display("FAIL %s: actual rises=%0d highs=%0d expected rises=%0d highs=%0d",
                 it.tag, rises, highs, it.exp_rises, it.exp_highs);
      end
      done = 1'b1;
    end
  end

  task automatic run_switch_check;
    logic prev, s, seen_low;
    int run, bad;
    rate_code = 4'd6;
    settle(24);
    prev = 1'b0; seen_low = 1'b0; run = 0; bad = 0;
    for (int i = 0; i < 120; i++) begin
      if (i == 21) rate_code = 4'd3;
      if (i % 2 == 0) begin @(posedge clk); #2; end
      else begin @(negedge clk); #2; end
      s = clk_out;
      if (s) run++;
      if (!s && prev && seen_low && run != 2 && run != 4) bad++;
      if (!s) begin seen_low = 1'b1; run = 0; end
      prev = s;
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R9: actual %0d runt pulses expected 0", bad);
    end
  endtask

  initial begin : driver
    settle(3);
    rst_n = 1'b1;
    expect_ratio(0, "R8 reset output low");
    codec_en = 1'b1;
    for (int c = 0; c < 9; c++) begin
      rate_code = 4'(c);
      expect_ratio(c < 3 ? 1 : (c < 6 ? 2 : 4), $sformatf("R2 code %0d", c));
    end
    rate_code = 4'd12;
    expect_ratio(1, "R3 unknown code");
    rate_code = 4'd6;
    write_cfg(18'h00100);
    expect_ratio(4, "R6 write ignored without dsp");
    dsp_en = 1'b1;
    write_cfg(18'h20000);
    expect_ratio(8, "R5 extra halving");
    write_cfg(18'h20100);
    expect_ratio(1, "R4 bypass");
    write_cfg(18'h20000);
    dsp_en = 1'b0;
    rate_code = 4'd3;
    expect_ratio(4, "R7 retained after dsp off");
    codec_en = 1'b0;
    expect_ratio(0, "R1 both enables low");
    dsp_en = 1'b1;
    write_cfg(18'h00000);
    expect_ratio(2, "R1 dsp alone runs, R10 duty");
    run_switch_check();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule